// File: doc/BRIEF.md
# Memory Frequency-Change Handshake Register

This block sits between a memory controller and software that services memory frequency changes. The controller raises a request line and presents a 5-bit code for the target frequency point. The block records the request, raises an interrupt flag and holds the code in one 32-bit status and control word. Software reads that word over a single-register bus. A request is new only when the request bit and the interrupt flag are both set. Software does the change, then writes the acknowledge bit. The acknowledge goes back to the controller as a level.

The acknowledge stays high until the controller drops its request. The block clears it in hardware on the cycle after the request input falls. Software waits for the acknowledge to read back as 0 before it polls again, so it never sees an old request twice. The interrupt flag lasts longer than the request. Software clears it by writing 1 to it.

Top module: `fcr_handshake_reg`

## Requirements
- R1: Synchronous reset clears every state bit: the read word is 0x00000000 and the acknowledge output is 0.
- R2: Bit 7 of the read word equals the request input as it was sampled at the previous clock edge. A write does not change bit 7.
- R3: Bit 15 (interrupt flag) is set at the clock edge that samples a rising request. It stays set after the request falls. Writing 1 to bit 15 clears it, and writing 0 to bit 15 leaves it unchanged.
- R4: Bits 4:0 hold the type code captured at the edge where the request rose. They keep that value while the request stays high, even if the type input changes. They read as 0 while no request is pending.
- R5: Writing 1 to bit 6 while bit 7 reads 1 sets the acknowledge. Bit 6 of the read word and the acknowledge output both show it from the next cycle.
- R6: The acknowledge stays set while the request stays high, and a write of 0 to bit 6 does not clear it. It clears at the edge that samples the request input low after it was high.
- R7: Writing 1 to bit 6 while bit 7 reads 0 is ignored, and the acknowledge stays 0.
- R8: Bits 31:16, 14:8 and 5 always read as 0, and writes to them have no effect.
- R9: When a rising request and a clearing write to bit 15 arrive at the same edge, the flag ends up set. When a falling request and an acknowledge write arrive at the same edge, the acknowledge ends up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_req_i | input | 1 | Frequency-change request from the memory controller |
| freq_type_i | input | 5 | Requested frequency-point code |
| freq_ack_o | output | 1 | Acknowledge level returned to the controller |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, always valid |

## Verification
If the acknowledge is held past the request's fall, the acknowledge output stays high and bit 6 stays set on the cycle after the request is sampled low. If the edge detection is wrong, bit 15 is missing, or a second flag shows up, on the first read after the request rises. If the type capture is wrong, bits 4:0 change on the cycle after the type input changes while the request is still high. The stimulus table runs full handshakes and handshakes where the request is withdrawn before it is acknowledged. Directed cases then force a set and a clear onto the same edge, for both the flag and the acknowledge.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned TYPE_W    = 5;

    // Bit positions software decodes
    localparam int unsigned POS_ACK   = 6;
    localparam int unsigned POS_REQ   = 7;
    localparam int unsigned POS_IRQ   = 15;

    localparam logic [WORD_W-1:0] TYPE_MASK = WORD_W'((1 << TYPE_W) - 1);
    localparam logic [WORD_W-1:0] LIVE_MASK =
        TYPE_MASK | (WORD_W'(1) << POS_ACK) | (WORD_W'(1) << POS_REQ) | (WORD_W'(1) << POS_IRQ);
    localparam logic [WORD_W-1:0] RSVD_MASK = ~LIVE_MASK;

    typedef struct packed {
        logic              pending;
        logic              rise;
        logic              fall;
        logic [TYPE_W-1:0] code;
    } req_view_t;

    typedef struct packed {
        logic set_ack;
        logic clr_irq;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(input logic we, input logic [WORD_W-1:0] wd);
        wr_cmd_t c;
        c.set_ack = we & wd[POS_ACK];
        c.clr_irq = we & wd[POS_IRQ];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input req_view_t rv,
                                                    input logic ack,
                                                    input logic irq);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_REQ] = rv.pending;
        w[POS_ACK] = ack;
        w[POS_IRQ] = irq;
        w[TYPE_W-1:0] = rv.pending ? rv.code : '0;
        return w;
    endfunction

endpackage

// File: rtl/fcr_req_track.sv
module fcr_req_track
    import fcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [TYPE_W-1:0] type_i,
    output req_view_t         view_o
);
    logic              req_q;
    logic [TYPE_W-1:0] code_q;
    logic              rise;
    logic              fall;

    assign rise = req_i & ~req_q;
    assign fall = ~req_i & req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            code_q <= '0;
        end else begin
            req_q <= req_i;
            if (rise)
                code_q <= type_i;
            else if (fall)
                code_q <= '0;
        end
    end

    assign view_o.pending = req_q;
    assign view_o.rise    = rise;
    assign view_o.fall    = fall;
    assign view_o.code    = code_q;

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_q && req_i) |=> $stable(code_q)) else $error("code changed while pending"); // R4
endmodule

// File: rtl/fcr_irq_flag.sv
module fcr_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o) else $error("flag lost on rise"); // R9
endmodule

// File: rtl/fcr_ack_ctrl.sv
module fcr_ack_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic pending_i,
    input  logic fall_i,
    input  logic set_i,
    output logic ack_o
);
    always_ff @(posedge clk) begin
        if (rst)
            ack_o <= 1'b0;
        else if (fall_i)
            ack_o <= 1'b0;
        else if (set_i && pending_i)
            ack_o <= 1'b1;
    end

    AST_ACK_DROPS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        fall_i |=> !ack_o) else $error("ack survived fall"); // R6
endmodule

// File: rtl/fcr_handshake_reg.sv
module fcr_handshake_reg
    import fcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              freq_req_i,
    input  logic [TYPE_W-1:0] freq_type_i,
    output logic              freq_ack_o,
    input  logic              bus_we_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o
);
    req_view_t rv;
    wr_cmd_t   cmd;
    logic      irq_q;
    logic      ack_q;

    assign cmd = decode_write(bus_we_i, bus_wdata_i);

    fcr_req_track u_track (
        .clk    (clk),
        .rst    (rst),
        .req_i  (freq_req_i),
        .type_i (freq_type_i),
        .view_o (rv)
    );

    fcr_irq_flag u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_i  (rv.rise),
        .clr_i  (cmd.clr_irq),
        .flag_o (irq_q)
    );

    fcr_ack_ctrl u_ack (
        .clk       (clk),
        .rst       (rst),
        .pending_i (rv.pending),
        .fall_i    (rv.fall),
        .set_i     (cmd.set_ack),
        .ack_o     (ack_q)
    );

    assign freq_ack_o  = ack_q;
    assign bus_rdata_o = pack_word(rv, ack_q, irq_q);

    AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        freq_ack_o |-> bus_rdata_o[POS_REQ]) else $error("ack without request"); // R7
    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bus_rdata_o[POS_REQ] == $past(freq_req_i))) else $error("bit 7 mismatch"); // R2
    AST_RSVD_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && ((bus_wdata_i & RSVD_MASK) != '0)) |=> ((bus_rdata_o & RSVD_MASK) == '0))
        else $error("reserved bit visible"); // R8
    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (freq_ack_o && freq_req_i) |=> freq_ack_o) else $error("ack dropped early"); // R6
endmodule

// File: tb/tb_fcr_handshake_reg.sv
module tb_fcr_handshake_reg;
    import fcr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [4:0]        typ = '0;
    logic              we  = 1'b0;
    logic [31:0]       wd  = '0;
    logic              ack;
    logic [31:0]       rd;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    fcr_handshake_reg dut (
        .clk(clk), .rst(rst), .freq_req_i(req), .freq_type_i(typ),
        .freq_ack_o(ack), .bus_we_i(we), .bus_wdata_i(wd), .bus_rdata_o(rd)
    );

    typedef struct packed {
        logic        v_req;
        logic [4:0]  v_typ;
        logic        v_we;
        logic [31:0] v_wd;
        logic [31:0] v_rd;
        logic        v_ack;
        logic [3:0]  v_tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'h00, 1'b0, 32'h0,        32'h0,        1'b0, 4'd2}, // R2 idle
        '{1'b1, 5'h0A, 1'b0, 32'h0,        32'h0000808A, 1'b0, 4'd3}, // R3 rise sets flag, R4 capture
        '{1'b1, 5'h1F, 1'b0, 32'h0,        32'h0000808A, 1'b0, 4'd4}, // R4 type held
        '{1'b1, 5'h1F, 1'b1, 32'hFFFF7FBF, 32'h0000808A, 1'b0, 4'd8}, // R8 reserved writes ignored
        '{1'b1, 5'h1F, 1'b1, 32'h00000040, 32'h000080CA, 1'b1, 4'd5}, // R5 ack set
        '{1'b1, 5'h1F, 1'b0, 32'h0,        32'h000080CA, 1'b1, 4'd6}, // R6 ack held
        '{1'b1, 5'h1F, 1'b1, 32'h00008000, 32'h000000CA, 1'b1, 4'd3}, // R3 write-1 clears flag
        '{1'b1, 5'h1F, 1'b1, 32'h00000000, 32'h000000CA, 1'b1, 4'd6}, // R6 write 0 keeps ack
        '{1'b0, 5'h1F, 1'b0, 32'h0,        32'h00000000, 1'b0, 4'd6}, // R6 fall clears ack
        '{1'b0, 5'h00, 1'b1, 32'h00000040, 32'h00000000, 1'b0, 4'd7}, // R7 ack with no request
        '{1'b1, 5'h03, 1'b0, 32'h0,        32'h00008083, 1'b0, 4'd2}, // R2 second request
        '{1'b0, 5'h03, 1'b0, 32'h0,        32'h00008000, 1'b0, 4'd3}, // R3 flag outlives request
        '{1'b0, 5'h00, 1'b1, 32'h00008000, 32'h00000000, 1'b0, 4'd3}  // R3 flag cleared
    };

    task automatic check(input string tag, input logic [31:0] exp_rd, input logic exp_ack);
        n_checks++;
        if (rd !== exp_rd || ack !== exp_ack) begin
            n_errors++;
            $display("FAIL %s: rdata=%h ack=%b expected rdata=%h ack=%b", tag, rd, ack, exp_rd, exp_ack);
        end
    endtask

    task automatic step(input logic r, input logic [4:0] t, input logic w, input logic [31:0] d);
        req = r; typ = t; we = w; wd = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].v_req, VECS[i].v_typ, VECS[i].v_we, VECS[i].v_wd);
            check($sformatf("R%0d vector %0d", VECS[i].v_tag, i), VECS[i].v_rd, VECS[i].v_ack);
        end

        // R9: rise and flag clear on the same edge, set wins
        step(1'b1, 5'h11, 1'b1, 32'h00008000);
        check("R9 rise beats clear", 32'h00008091, 1'b0);
        // R9: fall and ack write on the same edge, clear wins
        step(1'b0, 5'h11, 1'b1, 32'h00000040);
        check("R9 fall beats ack set", 32'h00008000, 1'b0);
        // R2: bit 7 write does not create a request
        step(1'b0, 5'h00, 1'b1, 32'h00000080);
        check("R2 bit 7 not writable", 32'h00008000, 1'b0);
        // R1: reset from a busy state
        step(1'b1, 5'h07, 1'b0, 32'h0);
        step(1'b1, 5'h07, 1'b1, 32'h00000040);
        check("R5 ack before reset", 32'h000080C7, 1'b1);
        rst = 1'b1;
        step(1'b1, 5'h07, 1'b0, 32'h0);
        check("R1 reset clears busy state", 32'h0, 1'b0);
        rst = 1'b0;
        req = 1'b0;
        step(1'b0, 5'h00, 1'b0, 32'h0);
        check("R1 idle after reset", 32'h0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule